// File: doc/BRIEF.md
# Serial Scan Test Port for Memory Macros

This block lets an outside tester reach a bank of on-chip memory macros using only a handful of pins. The tester clocks a 112-bit command word into a shift register one bit per clock. The word carries a macro select code and two independent port commands, one for each of the two memory ports. Each port command holds an address, write data, an active-low chip select and an active-low write enable.

Holding the global strobe low for one clock runs the coded access on the selected macro. When the strobe goes high again, the read data of both ports is latched into a capture bank. A one-clock load pulse then copies the captured words into the two data fields of the shift register. Shifting out returns the command word with the read results in place of the write data.

The memories are simple behavioural stand-ins. Select codes 0 to 4 reach dual-port macros and codes 8 to 11 reach single-port macros. Every other code has no macro behind it.

Top module: `scan_mem_tap`

## Requirements
- R1: While `rst_n` is low, the shift register and the capture bank are cleared asynchronously and `scan_do` reads 0. The core leaves reset on the second rising clock edge after `rst_n` goes high.
- R2: On each rising edge with `scan_en` high, the register shifts one place toward bit 111 and takes `scan_di` into bit 0. After 112 such edges the first bit sent sits in bit 111.
- R3: On an edge where `scan_en` and `load_en` are both low, the register keeps its contents, including a partly shifted word.
- R4: `scan_do` always equals bit 111 of the register. The first bit of a word is therefore readable before the first shift edge.
- R5: Field positions in the word:
  - select [111:108];
  - port A address [107:92], data [91:60], chip select 59, write enable 58, spare [57:54];
  - port B address [53:38], data [37:6], chip select 5, write enable 4, spare [3:0].
- R6: On an edge where `gcs_n` is low, each port of the selected macro acts as follows:
  - chip select 0 and write enable 0: it writes its data;
  - chip select 0 and write enable 1: it reads;
  - chip select 1: it does nothing.

  Only the low 4 address bits are used, so each macro holds 16 words. If both ports write the same word, port B's value is stored.
- R7: On the first edge with `gcs_n` high after an edge with it low, the read data of both ports is captured. A port that wrote or was idle captures zero. The capture bank changes at no other time.
- R8: On an edge with `load_en` high and `scan_en` low, both data fields are replaced by the captured words. Select, addresses, chip selects, write enables and spare bits are unchanged.
- R9: Codes 0 to 4 each select a dual-port macro whose two ports share one array. Codes 8 to 11 each select a single-port macro that ignores the port B fields and captures zero on port B.
- R10: A select code with no macro behind it writes nothing, and both ports capture zero.
- R11: An access through one select code leaves the contents of every other macro unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shift and access clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scan_en | input | 1 | Shift enable |
| load_en | input | 1 | Copy captured read data into the data fields |
| scan_di | input | 1 | Serial data in, MSB first |
| gcs_n | input | 1 | Active-low global access strobe |
| scan_do | output | 1 | Serial data out, bit 111 of the register |

## Verification
A table of command words is run through the full shift-in, strobe, load and shift-out cycle. The words cover these cases:
- writes, then reads of the same words on both ports of a dual-port macro;
- a write through one port that is read back through the other;
- a single-port macro whose port B fields try to write and read;
- an unmapped code that tries to overwrite data;
- addresses above 15;
- both ports writing one word.

Comparing each returned word against hand-computed values separates several faults: field misplacement, a wrong port priority, a missing address wrap, leakage between macros, and a port B that is not ignored. Directed runs add the following:
- a word paused in mid-shift;
- a load with no strobe before it, which must return the earlier capture;
- an asynchronous reset that lands on a loaded word.

// File: rtl/scan_mem_pkg.sv
package scan_mem_pkg;
  localparam int SEL_W  = 4;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 32;
  localparam int PAD_W  = 4;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
    logic              csb;
    logic              web;
    logic [PAD_W-1:0]  pad;
  } port_cmd_t;

  typedef struct packed {
    logic [SEL_W-1:0] sel;
    port_cmd_t        pa;
    port_cmd_t        pb;
  } scan_word_t;

  localparam int SCAN_W    = $bits(scan_word_t);
  localparam int NUM_CODES = 1 << SEL_W;
endpackage

// File: rtl/scan_shift_reg.sv
module scan_shift_reg
  import scan_mem_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scan_en,
  input  logic              load_en,
  input  logic              scan_di,
  input  logic [DATA_W-1:0] cap_a,
  input  logic [DATA_W-1:0] cap_b,
  output scan_word_t        word_q
);
  localparam port_cmd_t PORT_KEEP = '{addr: '1, data: '0, csb: 1'b1, web: 1'b1, pad: '1};
  localparam scan_word_t KEEP_MASK = '{sel: '1, pa: PORT_KEEP, pb: PORT_KEEP};

  scan_word_t        word_d;
  logic [SCAN_W-1:0] flat_q;
  logic              upd;

  assign flat_q = word_q;
  assign upd    = scan_en | load_en;

  always_comb begin
    word_d = word_q;
    if (scan_en) begin
      word_d = scan_word_t'({flat_q[SCAN_W-2:0], scan_di});
    end else if (load_en) begin
      word_d.pa.data = cap_a;
      word_d.pb.data = cap_b;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
    end else if (upd) begin
      word_q <= word_d;
    end
  end

  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!scan_en && !load_en) |=> $stable(flat_q));

  a_r2_shift: assert property (@(posedge clk) disable iff (!rst_n)
    scan_en |=> (flat_q[SCAN_W-1:1] == $past(flat_q[SCAN_W-2:0])) && (flat_q[0] == $past(scan_di)));

  a_r8_load_keeps_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    (load_en && !scan_en) |=> ((flat_q & KEEP_MASK) == ($past(flat_q) & KEEP_MASK))
                              && (word_q.pa.data == $past(cap_a)) && (word_q.pb.data == $past(cap_b)));
endmodule

// File: rtl/scan_mem_macro.sv
module scan_mem_macro
  import scan_mem_pkg::*;
#(
  parameter int AW   = 4,
  parameter bit DUAL = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc,
  input  port_cmd_t         pa,
  input  port_cmd_t         pb,
  output logic [DATA_W-1:0] rd_a,
  output logic [DATA_W-1:0] rd_b
);
  localparam int DEPTH = 1 << AW;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     addr_a, addr_b;
  logic              wr_a, rd_en_a, wr_b, rd_en_b;
  logic              unused_bits;

  assign addr_a  = pa.addr[AW-1:0];
  assign addr_b  = pb.addr[AW-1:0];
  assign wr_a    = acc && !pa.csb && !pa.web;
  assign rd_en_a = acc && !pa.csb && pa.web;
  assign unused_bits = ^{pa, pb};

  generate
    if (DUAL) begin : g_dual
      assign wr_b    = acc && !pb.csb && !pb.web;
      assign rd_en_b = acc && !pb.csb && pb.web;
    end else begin : g_single
      assign wr_b    = 1'b0;
      assign rd_en_b = 1'b0;
    end
  endgenerate

  // port B write is applied after port A so it wins on a shared word
  always_ff @(posedge clk) begin
    if (wr_a) mem[addr_a] <= pa.data;
    if (wr_b) mem[addr_b] <= pb.data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_a <= '0;
      rd_b <= '0;
    end else if (acc) begin
      rd_a <= rd_en_a ? mem[addr_a] : '0;
      rd_b <= rd_en_b ? mem[addr_b] : '0;
    end
  end

  a_r6_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> ($stable(rd_a) && $stable(rd_b)));

  a_r6_deselected_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && pa.csb) |=> (rd_a == '0));
endmodule

// File: rtl/scan_rd_capture.sv
module scan_rd_capture
  import scan_mem_pkg::*;
#(
  parameter int NUM_DP  = 5,
  parameter int SP_BASE = 8,
  parameter int NUM_SP  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              gcs_n,
  input  logic [SEL_W-1:0]  sel,
  input  logic [DATA_W-1:0] rd_a_bus [NUM_CODES],
  input  logic [DATA_W-1:0] rd_b_bus [NUM_CODES],
  output logic [DATA_W-1:0] cap_a,
  output logic [DATA_W-1:0] cap_b
);
  logic gcs_prev;
  logic strobe_end;
  logic sel_dp, sel_sp;

  assign strobe_end = gcs_n && !gcs_prev;
  assign sel_dp     = int'(sel) < NUM_DP;
  assign sel_sp     = (int'(sel) >= SP_BASE) && (int'(sel) < SP_BASE + NUM_SP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gcs_prev <= 1'b1;
    end else begin
      gcs_prev <= gcs_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_a <= '0;
      cap_b <= '0;
    end else if (strobe_end) begin
      cap_a <= rd_a_bus[sel];
      cap_b <= rd_b_bus[sel];
    end
  end

  a_r7_capture_only_at_strobe_end: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(gcs_n) |=> ($stable(cap_a) && $stable(cap_b)));

  a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(gcs_n) && !sel_dp && !sel_sp) |=> (cap_a == '0 && cap_b == '0));

  a_r9_single_port_b_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(gcs_n) && sel_sp) |=> (cap_b == '0));
endmodule

// File: rtl/scan_mem_tap.sv
module scan_mem_tap
  import scan_mem_pkg::*;
#(
  parameter int NUM_DP  = 5,
  parameter int SP_BASE = 8,
  parameter int NUM_SP  = 4,
  parameter int MEM_AW  = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scan_en,
  input  logic load_en,
  input  logic scan_di,
  input  logic gcs_n,
  output logic scan_do
);
  logic [1:0]        rst_sync;
  logic              core_rst_n;
  scan_word_t        word_q;
  logic [DATA_W-1:0] cap_a, cap_b;
  logic [DATA_W-1:0] rd_a_bus [NUM_CODES];
  logic [DATA_W-1:0] rd_b_bus [NUM_CODES];

  // asynchronous assertion, release after two edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync <= '0;
    end else begin
      rst_sync <= {rst_sync[0], 1'b1};
    end
  end
  assign core_rst_n = rst_sync[1];

  scan_shift_reg u_shift (
    .clk     (clk),
    .rst_n   (core_rst_n),
    .scan_en (scan_en),
    .load_en (load_en),
    .scan_di (scan_di),
    .cap_a   (cap_a),
    .cap_b   (cap_b),
    .word_q  (word_q)
  );

  assign scan_do = word_q.sel[SEL_W-1];

  generate
    for (genvar c = 0; c < NUM_CODES; c++) begin : g_code
      logic acc;
      assign acc = !gcs_n && (word_q.sel == SEL_W'(c));
      if (c < NUM_DP) begin : g_dp
        scan_mem_macro #(.AW(MEM_AW), .DUAL(1'b1)) u_mac (
          .clk (clk), .rst_n (core_rst_n), .acc (acc),
          .pa (word_q.pa), .pb (word_q.pb),
          .rd_a (rd_a_bus[c]), .rd_b (rd_b_bus[c])
        );
      end else if (c >= SP_BASE && c < SP_BASE + NUM_SP) begin : g_sp
        scan_mem_macro #(.AW(MEM_AW), .DUAL(1'b0)) u_mac (
          .clk (clk), .rst_n (core_rst_n), .acc (acc),
          .pa (word_q.pa), .pb (word_q.pb),
          .rd_a (rd_a_bus[c]), .rd_b (rd_b_bus[c])
        );
      end else begin : g_none
        logic unused_acc;
        assign unused_acc  = acc;
        assign rd_a_bus[c] = '0;
        assign rd_b_bus[c] = '0;
      end
    end
  endgenerate

  scan_rd_capture #(.NUM_DP(NUM_DP), .SP_BASE(SP_BASE), .NUM_SP(NUM_SP)) u_cap (
    .clk      (clk),
    .rst_n    (core_rst_n),
    .gcs_n    (gcs_n),
    .sel      (word_q.sel),
    .rd_a_bus (rd_a_bus),
    .rd_b_bus (rd_b_bus),
    .cap_a    (cap_a),
    .cap_b    (cap_b)
  );

  a_r4_out_is_msb: assert property (@(posedge clk) disable iff (!core_rst_n)
    scan_en |=> (scan_do == $past(word_q.sel[SEL_W-2])));
endmodule

// File: tb/scan_mem_tap_tb_top.sv
module scan_mem_tap_tb_top;
  localparam real CLK_HALF   = 2.5;
  localparam int  WD_CYCLES  = 150000;
  localparam int  NV         = 13;
  localparam logic [3:0] PAD = 4'hA;

  logic clk = 1'b0;
  logic rst_n, scan_en, load_en, scan_di, gcs_n;
  logic scan_do;
  int checks = 0;
  int errors = 0;

  always #(CLK_HALF) clk = ~clk;

  scan_mem_tap dut_i (
    .clk (clk), .rst_n (rst_n), .scan_en (scan_en), .load_en (load_en),
    .scan_di (scan_di), .gcs_n (gcs_n), .scan_do (scan_do)
  );

  // sel, addrA, dataA, csA, weA, addrB, dataB, csB, weB, expect A, expect B
  localparam logic [167:0] VEC [NV] = '{
    {4'd0, 16'h0001, 32'h11111111, 1'b0, 1'b0, 16'h0000, 32'h00000000, 1'b1, 1'b1, 32'h0, 32'h0},
    {4'd0, 16'h0002, 32'hA5A5A5A5, 1'b0, 1'b0, 16'h0003, 32'h5A5A5A5A, 1'b0, 1'b0, 32'h0, 32'h0},
    {4'd0, 16'h0001, 32'h00000000, 1'b0, 1'b1, 16'h0003, 32'h00000000, 1'b0, 1'b1, 32'h11111111, 32'h5A5A5A5A},
    {4'd4, 16'h0000, 32'h77777777, 1'b1, 1'b1, 16'h0000, 32'hCAFEF00D, 1'b0, 1'b0, 32'h0, 32'h0},
    {4'd4, 16'h0000, 32'h00000000, 1'b0, 1'b1, 16'h0000, 32'h00000000, 1'b0, 1'b1, 32'hCAFEF00D, 32'hCAFEF00D},
    {4'd9, 16'h0005, 32'hDEADBEEF, 1'b0, 1'b0, 16'h0005, 32'h12345678, 1'b0, 1'b0, 32'h0, 32'h0},
    {4'd9, 16'h0005, 32'h00000000, 1'b0, 1'b1, 16'h0005, 32'h00000000, 1'b0, 1'b1, 32'hDEADBEEF, 32'h0},
    {4'd6, 16'h0001, 32'hFFFFFFFF, 1'b0, 1'b0, 16'h0002, 32'hFFFFFFFF, 1'b0, 1'b0, 32'h0, 32'h0},
    {4'd6, 16'h0001, 32'h00000000, 1'b0, 1'b1, 16'h0002, 32'h00000000, 1'b0, 1'b1, 32'h0, 32'h0},
    {4'd0, 16'h0001, 32'h00000000, 1'b0, 1'b1, 16'h0002, 32'h00000000, 1'b0, 1'b1, 32'h11111111, 32'hA5A5A5A5},
    {4'd0, 16'h0011, 32'h00000000, 1'b0, 1'b1, 16'h0013, 32'h00000000, 1'b0, 1'b1, 32'h11111111, 32'h5A5A5A5A},
    {4'd2, 16'h0007, 32'h00000001, 1'b0, 1'b0, 16'h0007, 32'h00000002, 1'b0, 1'b0, 32'h0, 32'h0},
    {4'd2, 16'h0007, 32'h00000000, 1'b0, 1'b1, 16'h0007, 32'h00000000, 1'b0, 1'b1, 32'h2, 32'h2}
  };

  function automatic logic [111:0] mkw(input logic [3:0] s, input logic [15:0] aa,
      input logic [31:0] da, input logic ca, input logic wa, input logic [15:0] ab,
      input logic [31:0] db, input logic cb, input logic wb);
    return {s, aa, da, ca, wa, PAD, ab, db, cb, wb, PAD};
  endfunction

  task automatic chk(input string tag, input logic [111:0] got, input logic [111:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic shift_bits(input logic [111:0] w, input int from, input int upto);
    for (int j = from; j < upto; j++) begin
      @(negedge clk);
      scan_en = 1'b1;
      scan_di = w[111-j];
    end
    @(negedge clk);
    scan_en = 1'b0;
  endtask

  task automatic do_load();
    @(negedge clk); load_en = 1'b1;
    @(negedge clk); load_en = 1'b0;
  endtask

  task automatic do_access();
    @(negedge clk); gcs_n = 1'b0;
    @(negedge clk); gcs_n = 1'b1;
    do_load();
  endtask

  task automatic shift_out(output logic [111:0] got);
    for (int j = 0; j < 112; j++) begin
      got[111-j] = scan_do;
      scan_en = 1'b1;
      scan_di = 1'b0;
      @(negedge clk);
    end
    scan_en = 1'b0;
  endtask

  initial begin
    #(WD_CYCLES * 2 * CLK_HALF);
    errors++;
    $display("FAIL R2 watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [111:0] got, w, cmd;
    rst_n = 1'b0; scan_en = 1'b0; load_en = 1'b0; scan_di = 1'b0; gcs_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 out low in reset", {111'd0, scan_do}, 112'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 R8: capture bank and register are zero after reset
    do_load();
    shift_out(got);
    chk("R1 R8 cleared state", got, 112'd0);

    // table: R5 R6 R7 R8 R9 R10 R11
    for (int v = 0; v < NV; v++) begin
      logic [167:0] e;
      e   = VEC[v];
      cmd = mkw(e[167:164], e[163:148], e[147:116], e[115], e[114],
                e[113:98], e[97:66], e[65], e[64]);
      w   = mkw(e[167:164], e[163:148], e[63:32], e[115], e[114],
                e[113:98], e[31:0], e[65], e[64]);
      shift_bits(cmd, 0, 112);
      do_access();
      shift_out(got);
      chk($sformatf("R5 R6 R7 R8 R9 R10 R11 vector %0d", v), got, w);
    end

    // R7: load without a strobe returns the previous capture (2, 2)
    cmd = mkw(4'd0, 16'h0001, 32'hFFFFFFFF, 1'b0, 1'b1, 16'h0002, 32'hEEEEEEEE, 1'b0, 1'b1);
    shift_bits(cmd, 0, 112);
    do_load();
    shift_out(got);
    chk("R7 no strobe keeps capture",
        got, mkw(4'd0, 16'h0001, 32'h2, 1'b0, 1'b1, 16'h0002, 32'h2, 1'b0, 1'b1));

    // R3 R2: pause in mid-shift
    w = mkw(4'd13, 16'hBEEF, 32'h0F1E2D3C, 1'b1, 1'b0, 16'h1234, 32'h89ABCDEF, 1'b0, 1'b1);
    shift_bits(w, 0, 50);
    repeat (6) @(negedge clk);
    shift_bits(w, 50, 112);
    shift_out(got);
    chk("R3 R2 paused shift", got, w);

    // R4: first bit visible before any shift edge
    w = mkw(4'd8, 16'h0, 32'h0, 1'b1, 1'b1, 16'h0, 32'h0, 1'b1, 1'b1);
    shift_bits(w, 0, 112);
    chk("R4 msb before shift", {111'd0, scan_do}, 112'd1);

    // R1: asynchronous clear of a loaded word
    rst_n = 1'b0;
    #1;
    chk("R1 async clear", {111'd0, scan_do}, 112'd0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    shift_out(got);
    chk("R1 register cleared", got, 112'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule